// File: doc/BRIEF.md
# Serial Configuration Chain Window

This block gives software access to a long serial chain of configuration bits through a six-bit window. It has two registers on a simple valid/ready register bus. The window register holds six bits. The fetch register is a write-one command. Writing the window register only stages six bits. The staged bits enter the chain after a separate commit strobe reports that the writing instruction has retired. A flush strobe that comes before the commit throws the staged bits away.

Writing 1 to bit 0 of the fetch register pulls the next six bits out of the chain and places them in the window, where a later read finds them. Each transfer moves one bit per clock for six clocks. While a transfer runs or bits are staged, the bus is held off. The chain length and its reset contents are parameters. Some positions in the chain mirror others, and software must give each mirror the same value as its original. The block does not enforce this.

Top module: `csr_chain_port`

## Requirements
- R1: After reset, `busy` is 0, `req_ready` is 1, the chain holds the `CHAIN_RST` parameter value and the window reads as zero.
- R2: A read of the window register (address `DATA_ADDR`, default 0) returns the window in bits [5:0] and zero above. A read of the fetch register (address `SHIFT_ADDR`, default 1) returns all zeros. Any other address reads zero, and writes to it change nothing.
- R3: A write to the window register stores `req_wdata[5:0]` and ignores the upper bits. It leaves the chain unchanged and drops `req_ready` until a commit or a flush arrives.
- R4: A commit while bits are staged raises `busy` at the next clock edge for exactly six cycles. The chain shifts one bit per cycle: bit 0 of the staged value goes first, enters at the top of the chain and moves toward bit 0. The result is new chain = {w[5:0], old[LEN-1:6]}. The window keeps w afterwards.
- R5: Writing the fetch register with bit 0 = 1 raises `busy` for six cycles. The chain rotates so that new chain = {old[5:0], old[LEN-1:6]}, and the window then reads old[5:0].
- R6: Writing the fetch register with bit 0 = 0 starts no transfer and leaves the chain and the window unchanged.
- R7: `req_ready` is 0 while `busy` is 1 or bits are staged. A request presented then waits, and it completes once the block is idle again.
- R8: A flush while bits are staged and no commit is present discards them: the chain is unchanged, the window reads zero and `req_ready` returns at the next cycle. If commit and flush arrive in the same cycle, the commit wins.
- R9: A commit with nothing staged has no effect: `busy` stays 0 and the chain is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Bus request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Register address |
| req_wdata | input | BUS_W | Write data |
| req_ready | output | 1 | Request accepted on this clock edge when high with req_valid |
| req_rdata | output | BUS_W | Read data, valid while a read is accepted |
| commit | input | 1 | Retire strobe for a staged window write |
| flush | input | 1 | Cancel strobe for a staged window write |
| busy | output | 1 | Serial transfer in progress |
| chain_q | output | CHAIN_LEN | Current chain contents |

## Verification
Read data is combinational and is due in the same cycle the read is accepted. The monitor therefore compares it at the falling edge where `req_valid` and `req_ready` are both high. A commit seen at one rising edge raises `busy` after that edge, and the chain is final six edges later. A fetch command behaves the same way, counted from the edge that accepts it. The bench counts the falling edges where `busy` is high, expects exactly six, and compares the chain against a reference that applies the R4 and R5 formulas once `busy` has dropped. Checks for no effect (fetch with bit 0 clear, a stray commit, a flush, an unmapped address) sample `busy` at the next falling edge. They then read the chain and the window back through the ports.

// File: rtl/csr_chain_pkg.sv
package csr_chain_pkg;
  typedef enum logic {
    XFER_FETCH = 1'b0,
    XFER_LOAD  = 1'b1
  } xfer_e;
endpackage

// File: rtl/csr_chain_regs.sv
module csr_chain_regs #(
  parameter int BUS_W = 64,
  parameter int ADDR_W = 4,
  parameter int WIN_W = 6,
  parameter logic [ADDR_W-1:0] DATA_ADDR = '0,
  parameter logic [ADDR_W-1:0] SHIFT_ADDR = 1,
  localparam int IDX_W = (WIN_W > 1) ? $clog2(WIN_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BUS_W-1:0]  req_wdata,
  output logic              req_ready,
  output logic [BUS_W-1:0]  req_rdata,
  input  logic              commit,
  input  logic              flush,
  input  logic              busy,
  input  logic              cap_en,
  input  logic [IDX_W-1:0]  cap_idx,
  input  logic              cap_bit,
  output logic [WIN_W-1:0]  win_q,
  output logic              start_load,
  output logic              start_fetch
);
  logic             pending_q, pending_d;
  logic [WIN_W-1:0] win_d;
  logic             idle, acc, hit_data, hit_shift, wr_win, drop;
  logic             unused_wdata;

  assign unused_wdata = ^req_wdata[BUS_W-1:WIN_W];

  assign idle        = !busy && !pending_q;
  assign req_ready   = idle;
  assign acc         = req_valid && idle;
  assign hit_data    = (req_addr == DATA_ADDR);
  assign hit_shift   = (req_addr == SHIFT_ADDR);
  assign wr_win      = acc && req_write && hit_data;
  assign start_fetch = acc && req_write && hit_shift && req_wdata[0];
  assign start_load  = pending_q && commit;
  assign drop        = pending_q && flush && !commit;

  always_comb begin
    pending_d = pending_q;
    if (wr_win) pending_d = 1'b1;
    if (start_load || drop) pending_d = 1'b0;
  end

  always_comb begin
    win_d = win_q;
    if (wr_win) win_d = req_wdata[WIN_W-1:0];
    if (drop) win_d = '0;
    if (cap_en) win_d[cap_idx] = cap_bit;
  end

  always_comb begin
    req_rdata = '0;
    if (acc && !req_write && hit_data) req_rdata[WIN_W-1:0] = win_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      win_q     <= '0;
    end else begin
      pending_q <= pending_d;
      win_q     <= win_d;
    end
  end

  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_rdata[BUS_W-1:WIN_W] == '0);

  // R8
  flush_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_q && flush && !commit) |=> (!pending_q && !busy && win_q == '0));

  // R3
  stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_q && !commit && !flush) |=> (pending_q && !req_ready));
endmodule

// File: rtl/csr_chain_seq.sv
module csr_chain_seq
  import csr_chain_pkg::*;
#(
  parameter int WIN_W = 6,
  localparam int IDX_W = (WIN_W > 1) ? $clog2(WIN_W) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_load,
  input  logic             start_fetch,
  output logic             busy,
  output xfer_e            mode,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(WIN_W - 1);

  logic             busy_q, busy_d;
  xfer_e            mode_q, mode_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    busy_d = busy_q;
    mode_d = mode_q;
    idx_d  = idx_q;
    if (start_load || start_fetch) begin
      busy_d = 1'b1;
      mode_d = start_load ? XFER_LOAD : XFER_FETCH;
      idx_d  = '0;
    end else if (busy_q) begin
      if (idx_q == LAST) begin
        busy_d = 1'b0;
        idx_d  = '0;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      mode_q <= XFER_FETCH;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      mode_q <= mode_d;
      idx_q  <= idx_d;
    end
  end

  assign busy = busy_q;
  assign mode = mode_q;
  assign idx  = idx_q;

  // R4 R5
  xfer_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> ($past(idx_q) == LAST));

  // R4 R5
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !(start_load || start_fetch));
endmodule

// File: rtl/csr_chain_store.sv
module csr_chain_store #(
  parameter int CHAIN_LEN = 45,
  parameter logic [CHAIN_LEN-1:0] CHAIN_RST = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shift_en,
  input  logic                 in_bit,
  output logic [CHAIN_LEN-1:0] chain_q
);
  logic [CHAIN_LEN-1:0] chain_d;

  always_comb begin
    chain_d = chain_q;
    if (shift_en) chain_d = {in_bit, chain_q[CHAIN_LEN-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= CHAIN_RST;
    else        chain_q <= chain_d;
  end
endmodule

// File: rtl/csr_chain_port.sv
module csr_chain_port
  import csr_chain_pkg::*;
#(
  parameter int BUS_W = 64,
  parameter int ADDR_W = 4,
  parameter int WIN_W = 6,
  parameter int CHAIN_LEN = 45,
  parameter logic [CHAIN_LEN-1:0] CHAIN_RST = '0,
  parameter logic [ADDR_W-1:0] DATA_ADDR = '0,
  parameter logic [ADDR_W-1:0] SHIFT_ADDR = 1,
  localparam int IDX_W = (WIN_W > 1) ? $clog2(WIN_W) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [BUS_W-1:0]     req_wdata,
  output logic                 req_ready,
  output logic [BUS_W-1:0]     req_rdata,
  input  logic                 commit,
  input  logic                 flush,
  output logic                 busy,
  output logic [CHAIN_LEN-1:0] chain_q
);
  logic [1:0]       rst_sync_q;
  logic             rst_sn;
  logic [WIN_W-1:0] win_q;
  logic             start_load, start_fetch;
  xfer_e            mode;
  logic [IDX_W-1:0] idx;
  logic             cap_en, in_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  assign cap_en = busy && (mode == XFER_FETCH);
  assign in_bit = (mode == XFER_LOAD) ? win_q[idx] : chain_q[0];

  csr_chain_regs #(
    .BUS_W(BUS_W), .ADDR_W(ADDR_W), .WIN_W(WIN_W),
    .DATA_ADDR(DATA_ADDR), .SHIFT_ADDR(SHIFT_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_sn),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .req_rdata(req_rdata),
    .commit(commit), .flush(flush), .busy(busy),
    .cap_en(cap_en), .cap_idx(idx), .cap_bit(chain_q[0]),
    .win_q(win_q), .start_load(start_load), .start_fetch(start_fetch)
  );

  csr_chain_seq #(.WIN_W(WIN_W)) u_seq (
    .clk(clk), .rst_n(rst_sn),
    .start_load(start_load), .start_fetch(start_fetch),
    .busy(busy), .mode(mode), .idx(idx)
  );

  csr_chain_store #(.CHAIN_LEN(CHAIN_LEN), .CHAIN_RST(CHAIN_RST)) u_store (
    .clk(clk), .rst_n(rst_sn),
    .shift_en(busy), .in_bit(in_bit), .chain_q(chain_q)
  );

  // R3 R6 R9
  chain_idle_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !busy |=> $stable(chain_q));

  // R7
  stall_busy_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    busy |-> !req_ready);
endmodule

// File: tb/tb_csr_chain_port.sv
module tb_csr_chain_port;
  localparam int L = 45;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_write, commit, flush;
  logic [3:0]    req_addr;
  logic [63:0]   req_wdata;
  logic          req_ready, busy;
  logic [63:0]   req_rdata;
  logic [L-1:0]  chain_q;

  csr_chain_port dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .req_rdata(req_rdata), .commit(commit), .flush(flush),
    .busy(busy), .chain_q(chain_q)
  );

  always #10 clk = ~clk;

  int total = 0;
  int fails = 0;
  logic [L-1:0] ref_chain;
  logic [5:0]   exp_win;

  typedef struct { string tag; logic [63:0] val; } exp_t;
  exp_t exp_q[$];

  task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: compares each accepted read against the scoreboard
  always @(negedge clk) begin
    if (rst_n && req_valid && req_ready && !req_write) begin
      if (exp_q.size() == 0) check(1'b0, "read with no expectation", req_rdata, 64'h0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        check(req_rdata == e.val, e.tag, req_rdata, e.val);
      end
    end
  end

  task automatic bus(input logic wr, input logic [3:0] a, input logic [63:0] d, output int stalls);
    stalls = 0;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    while (!req_ready) begin stalls++; @(negedge clk); end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [63:0] e, input string tag);
    int st;
    exp_t x;
    x.tag = tag; x.val = e;
    exp_q.push_back(x);
    bus(1'b0, a, 64'h0, st);
  endtask

  task automatic pulse_commit();
    commit = 1'b1; @(posedge clk); #1; commit = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    @(negedge clk);
    while (busy) begin n++; @(negedge clk); end
    @(posedge clk); #1;
  endtask

  task automatic load(input logic [5:0] w);
    int st, n;
    bus(1'b1, 4'd0, {58'h2aa_aaaa_aaaa_aaaa, w}, st);
    pulse_commit();
    wait_idle(n);
    check(n == 6, "R4 busy cycles", 64'(n), 64'd6);
    ref_chain = {w, ref_chain[L-1:6]};
    exp_win = w;
    check(chain_q == ref_chain, "R4 chain after load", 64'(chain_q), 64'(ref_chain));
  endtask

  task automatic fetch();
    int st, n;
    bus(1'b1, 4'd1, 64'hffff_0000_0000_0001, st);
    wait_idle(n);
    check(n == 6, "R5 busy cycles", 64'(n), 64'd6);
    exp_win = ref_chain[5:0];
    ref_chain = {ref_chain[5:0], ref_chain[L-1:6]};
    check(chain_q == ref_chain, "R5 chain after fetch", 64'(chain_q), 64'(ref_chain));
    rd(4'd0, 64'(exp_win), "R5 window after fetch");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 64'h0, 64'h0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int st, n;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    req_wdata = '0; commit = 1'b0; flush = 1'b0;
    ref_chain = '0; exp_win = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R1 reset state
    check(busy == 1'b0, "R1 busy", 64'(busy), 64'd0);
    check(req_ready == 1'b1, "R1 ready", 64'(req_ready), 64'd1);
    check(chain_q == ref_chain, "R1 chain", 64'(chain_q), 64'(ref_chain));
    rd(4'd0, 64'h0, "R1 window reads zero");
    rd(4'd1, 64'h0, "R2 fetch register reads zero");

    // R3: staged write holds off the bus and leaves the chain alone
    bus(1'b1, 4'd0, 64'hffff_ffff_ffff_ffe5, st);
    @(negedge clk);
    check(req_ready == 1'b0, "R3 ready low while staged", 64'(req_ready), 64'd0);
    @(negedge clk);
    check(chain_q == ref_chain, "R3 chain unchanged while staged", 64'(chain_q), 64'(ref_chain));
    @(posedge clk); #1;
    pulse_commit();
    wait_idle(n);
    check(n == 6, "R4 busy cycles", 64'(n), 64'd6);
    ref_chain = {6'h25, ref_chain[L-1:6]};
    exp_win = 6'h25;
    check(chain_q == ref_chain, "R4 chain first load", 64'(chain_q), 64'(ref_chain));
    rd(4'd0, 64'h25, "R2 R4 window low bits only");

    // R4 sequence of loads, wrapping past the chain length
    for (int i = 0; i < 9; i++) load(6'((i * 23 + 7) ^ (i << 2)));
    rd(4'd0, 64'(exp_win), "R4 window keeps last load");

    // R5 fetches
    fetch();
    fetch();

    // R6 fetch with bit 0 clear
    bus(1'b1, 4'd1, 64'hffff_ffff_ffff_fffe, st);
    @(negedge clk);
    check(busy == 1'b0, "R6 no transfer", 64'(busy), 64'd0);
    check(chain_q == ref_chain, "R6 chain unchanged", 64'(chain_q), 64'(ref_chain));
    @(posedge clk); #1;
    rd(4'd0, 64'(exp_win), "R6 window unchanged");

    // R7 read waits behind a fetch
    bus(1'b1, 4'd1, 64'h1, st);
    exp_win = ref_chain[5:0];
    ref_chain = {ref_chain[5:0], ref_chain[L-1:6]};
    begin
      exp_t x;
      x.tag = "R7 stalled read data"; x.val = 64'(exp_win);
      exp_q.push_back(x);
      bus(1'b0, 4'd0, 64'h0, st);
    end
    check(st == 6, "R7 read stalled for transfer", 64'(st), 64'd6);
    check(chain_q == ref_chain, "R7 chain after stalled fetch", 64'(chain_q), 64'(ref_chain));

    // R7 second write waits behind a staged one
    bus(1'b1, 4'd0, 64'h11, st);
    fork
      bus(1'b1, 4'd0, 64'h2c, st);
      begin @(posedge clk); #1; pulse_commit(); end
    join
    check(st >= 1, "R7 write held while staged", 64'(st), 64'd1);
    pulse_commit();
    wait_idle(n);
    ref_chain = {6'h2c, 6'h11, ref_chain[L-1:12]};
    exp_win = 6'h2c;
    check(chain_q == ref_chain, "R7 chain after two writes", 64'(chain_q), 64'(ref_chain));

    // R8 flush discards
    bus(1'b1, 4'd0, 64'h3f, st);
    flush = 1'b1; @(posedge clk); #1; flush = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b1, "R8 ready back after flush", 64'(req_ready), 64'd1);
    check(busy == 1'b0, "R8 no transfer after flush", 64'(busy), 64'd0);
    check(chain_q == ref_chain, "R8 chain unchanged after flush", 64'(chain_q), 64'(ref_chain));
    @(posedge clk); #1;
    rd(4'd0, 64'h0, "R8 window cleared by flush");
    exp_win = '0;

    // R9 stray commit
    pulse_commit();
    @(negedge clk);
    check(busy == 1'b0, "R9 stray commit ignored", 64'(busy), 64'd0);
    check(chain_q == ref_chain, "R9 chain unchanged", 64'(chain_q), 64'(ref_chain));
    @(posedge clk); #1;

    // R8 commit wins over flush
    bus(1'b1, 4'd0, 64'h1a, st);
    commit = 1'b1; flush = 1'b1; @(posedge clk); #1; commit = 1'b0; flush = 1'b0;
    wait_idle(n);
    check(n == 6, "R8 commit beats flush", 64'(n), 64'd6);
    ref_chain = {6'h1a, ref_chain[L-1:6]};
    exp_win = 6'h1a;
    check(chain_q == ref_chain, "R8 chain after commit+flush", 64'(chain_q), 64'(ref_chain));

    // R2 unmapped address
    bus(1'b1, 4'd5, 64'h3f, st);
    @(negedge clk);
    check(busy == 1'b0, "R2 unmapped write no transfer", 64'(busy), 64'd0);
    check(req_ready == 1'b1, "R2 unmapped write not staged", 64'(req_ready), 64'd1);
    @(posedge clk); #1;
    rd(4'd5, 64'h0, "R2 unmapped reads zero");
    rd(4'd0, 64'(exp_win), "R2 window untouched by unmapped write");
    check(chain_q == ref_chain, "R2 chain untouched", 64'(chain_q), 64'(ref_chain));

    repeat (3) @(posedge clk);
    check(exp_q.size() == 0, "all reads observed", 64'(exp_q.size()), 64'd0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule